// File: doc/BRIEF.md
# Boot ROM Access Lock Controller

This block sits between two processors and their boot ROMs and decides, read by read, whether a ROM access is served, blanked or left to the rest of the address map. Its control state is a 16-bit lock word. The secondary CPU can only set bits in this word. No write can clear a bit, so once a region is locked it stays locked until the next reset.

Each CPU port presents an address, an access size and a read strobe. The secondary port also presents the program counter of the instruction that makes the access, and a 16-bit protection boundary. For each read the block returns one of three results: a ROM select with a word index, a blanked result carrying an all-ones value sized to the access, or "not served". It also filters reads of a 64-bit device-identity value, and returns zero for every such read once the hide bit is set.

Top module: `bootrom_lock_ctrl`

## Requirements
- R1: After reset the lock word is 0x0101. The primary view then reads 0x01 and the full secondary view reads 0x0101.
- R2: A write of size 16 (size code 1) or 32 (size code 2) ORs `cfg_wr_data & 0x0703` into the lock word. No write ever clears a bit.
- R3: A byte write (size code 0) with `cfg_wr_hi`=0 can set only bits 1:0, taken from data bits 1:0. A byte write with `cfg_wr_hi`=1 can set only bits 10:8, taken from data bits 2:0. A write takes effect on the clock edge that samples its strobe.
- R4: `p_cfg_view` is the low byte of the lock word. `s_cfg_view` is the full word for sizes 1 and 2. For size 0 it is the byte chosen by `s_cfg_hi` (0 selects bits 7:0, 1 selects bits 15:8), zero-extended.
- R5: With lock bit 1 clear, a primary read at 0xFFFF0000 or above selects the extended ROM (`rom` code 2) with word index `addr[15:2]`. Whenever no ROM is selected, the word index is 0.
- R6: With lock bit 1 clear and lock bit 0 set, a primary read at 0xFFFF8000 or above is blanked.
- R7: With lock bit 1 set, a primary read in 0xFFFF0000–0xFFFF0FFF selects the legacy ROM (`rom` code 1) with word index `addr[11:2]`. A primary read at 0xFFFF1000 or above is then not served (`rom` code 0, not blanked). A read below 0xFFFF0000 is never served.
- R8: With lock bit 9 clear, a secondary read below 0x00010000 selects the extended ROM with word index `addr[15:2]`. If lock bit 8 is set, such a read at 0x00008000 or above is blanked.
- R9: With lock bit 9 clear, a secondary read below 0x00010000 is blanked when its program counter is 0x00010000 or above.
- R10: With lock bit 9 clear, a secondary read below 0x00010000 is blanked when the address is below the boundary input and the program counter is at or above it.
- R11: With lock bit 9 set, and for any secondary address at or above 0x00010000, the read is not served: `rom` code 0, not blanked. Secondary reads at or above 0x00010000 are never served, whatever the lock bits.
- R12: A blanked response carries 0xFF, 0xFFFF or 0xFFFFFFFF for size codes 0, 1 and 2 (and 3). Every other response carries 0.
- R13: An identity read returns the 64-bit value shifted right by 8×offset, masked to the access size. With lock bit 10 set, every identity read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Lock write strobe from the secondary CPU |
| cfg_wr_size | input | 2 | Write size code: 0 byte, 1 half, 2 word |
| cfg_wr_hi | input | 1 | Byte write targets the high byte |
| cfg_wr_data | input | 16 | Write data |
| p_cfg_view | output | 8 | Lock word as the primary CPU reads it |
| s_cfg_size | input | 2 | Secondary lock-read size code |
| s_cfg_hi | input | 1 | Secondary byte read takes the high byte |
| s_cfg_view | output | 16 | Lock word as the secondary CPU reads it |
| p_rd | input | 1 | Primary ROM read strobe |
| p_addr | input | 32 | Primary address |
| p_size | input | 2 | Primary size code |
| p_rsp_vld | output | 1 | Primary response valid |
| p_rsp_rom | output | 2 | Primary ROM select: 0 none, 1 legacy, 2 extended |
| p_rsp_blk | output | 1 | Primary read blanked |
| p_rsp_word | output | 14 | Primary ROM word index |
| p_rsp_ones | output | 32 | Primary forced value |
| s_rd | input | 1 | Secondary ROM read strobe |
| s_addr | input | 32 | Secondary address |
| s_pc | input | 32 | Program counter of the requesting instruction |
| s_size | input | 2 | Secondary size code |
| s_bound | input | 16 | Protection boundary |
| s_rsp_vld | output | 1 | Secondary response valid |
| s_rsp_rom | output | 2 | Secondary ROM select |
| s_rsp_blk | output | 1 | Secondary read blanked |
| s_rsp_word | output | 14 | Secondary ROM word index |
| s_rsp_ones | output | 32 | Secondary forced value |
| id_value | input | 64 | Device-identity value |
| id_rd | input | 1 | Identity read strobe |
| id_off | input | 3 | Byte offset into the identity value |
| id_size | input | 2 | Identity read size code |
| id_rsp_vld | output | 1 | Identity response valid |
| id_rsp_data | output | 32 | Identity read data |

## Verification
Lock writes land on the edge that samples the strobe. The two configuration views are combinational, so the bench reads them at the falling edge after that write edge. ROM and identity responses are registered: each is valid for exactly one cycle, starting at the edge that samples the read strobe. Each read is therefore driven at a falling edge, removed at the next falling edge, and its response is compared in that same half-cycle. The stimulus is a full sweep of every lock-bit combination reachable from reset, covering address, program-counter and boundary corners at all three sizes.

// File: rtl/bootlock_pkg.sv
package bootlock_pkg;

   typedef enum logic [1:0] {
      ROM_NONE   = 2'd0,
      ROM_LEGACY = 2'd1,
      ROM_EXT    = 2'd2
   } rom_sel_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;

   // lock word bit positions (behavioural: software decodes these)
   localparam int LK_P_HALF   = 0;
   localparam int LK_P_LEGACY = 1;
   localparam int LK_S_HALF   = 8;
   localparam int LK_S_OFF    = 9;
   localparam int LK_ID_HIDE  = 10;

   function automatic logic [31:0] ones_for(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: ones_for = 32'h0000_00FF;
         SZ_HALF: ones_for = 32'h0000_FFFF;
         default: ones_for = 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/bootlock_reg.sv
module bootlock_reg #(
   parameter logic [15:0] RST_VAL = 16'h0101,
   parameter logic [15:0] WR_MASK = 16'h0703
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [1:0]  wr_size,
   input  logic        wr_hi,
   input  logic [15:0] wr_data,
   input  logic [1:0]  rd_size,
   input  logic        rd_hi,
   output logic [15:0] lock,
   output logic [7:0]  pri_view,
   output logic [15:0] sec_view
);
   import bootlock_pkg::*;

   logic [15:0] set_bits;

   always_comb begin
      if (wr_size == SZ_BYTE) begin
         if (wr_hi) set_bits = {wr_data[7:0] & WR_MASK[15:8], 8'h00};
         else       set_bits = {8'h00, wr_data[7:0] & WR_MASK[7:0]};
      end else begin
         set_bits = wr_data & WR_MASK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  lock <= RST_VAL;
      else if (wr) lock <= lock | set_bits;
   end

   assign pri_view = lock[7:0];

   always_comb begin
      if (rd_size == SZ_BYTE) sec_view = rd_hi ? {8'h00, lock[15:8]} : {8'h00, lock[7:0]};
      else                    sec_view = lock;
   end

endmodule

// File: rtl/bootlock_pri_gate.sv
module bootlock_pri_gate #(
   parameter logic [31:0] BASE      = 32'hFFFF_0000,
   parameter int          EXT_BYTES = 65536,
   parameter int          LEG_BYTES = 4096,
   localparam int         WIW       = $clog2(EXT_BYTES) - 2,
   localparam int         LIW       = $clog2(LEG_BYTES) - 2
) (
   input  logic           rd,
   input  logic [31:0]    addr,
   input  logic [1:0]     size,
   input  logic           lk_half,
   input  logic           lk_legacy,
   output logic [1:0]     rom,
   output logic           blk,
   output logic [WIW-1:0] word,
   output logic [31:0]    ones
);
   import bootlock_pkg::*;

   localparam logic [31:0] EXT_SZ  = 32'(EXT_BYTES);
   localparam logic [31:0] HALF_SZ = 32'(EXT_BYTES / 2);
   localparam logic [31:0] LEG_SZ  = 32'(LEG_BYTES);

   logic [31:0] off;
   logic        in_rom;

   assign off    = addr - BASE;
   assign in_rom = (addr >= BASE) && (off < EXT_SZ);

   always_comb begin
      rom  = ROM_NONE;
      blk  = 1'b0;
      word = '0;
      if (rd && in_rom) begin
         if (!lk_legacy) begin
            if (lk_half && (off >= HALF_SZ)) blk = 1'b1;
            else begin
               rom  = ROM_EXT;
               word = off[WIW+1:2];
            end
         end else if (off < LEG_SZ) begin
            rom  = ROM_LEGACY;
            word = WIW'(off[LIW+1:2]);
         end
      end
      ones = blk ? ones_for(size) : 32'h0;
   end

endmodule

// File: rtl/bootlock_sec_gate.sv
module bootlock_sec_gate #(
   parameter int  EXT_BYTES = 65536,
   localparam int WIW       = $clog2(EXT_BYTES) - 2
) (
   input  logic           rd,
   input  logic [31:0]    addr,
   input  logic [31:0]    pc,
   input  logic [1:0]     size,
   input  logic [15:0]    bound,
   input  logic           lk_half,
   input  logic           lk_off,
   output logic [1:0]     rom,
   output logic           blk,
   output logic [WIW-1:0] word,
   output logic [31:0]    ones
);
   import bootlock_pkg::*;

   localparam logic [31:0] EXT_SZ  = 32'(EXT_BYTES);
   localparam logic [31:0] HALF_SZ = 32'(EXT_BYTES / 2);

   logic [31:0] bnd;
   logic        pc_out, below_guard;

   assign bnd         = {16'h0, bound};
   assign pc_out      = pc >= EXT_SZ;
   assign below_guard = (addr < bnd) && (pc >= bnd);

   always_comb begin
      rom  = ROM_NONE;
      blk  = 1'b0;
      word = '0;
      if (rd && (addr < EXT_SZ) && !lk_off) begin
         if ((lk_half && (addr >= HALF_SZ)) || pc_out || below_guard) blk = 1'b1;
         else begin
            rom  = ROM_EXT;
            word = addr[WIW+1:2];
         end
      end
      ones = blk ? ones_for(size) : 32'h0;
   end

endmodule

// File: rtl/bootlock_id_gate.sv
module bootlock_id_gate #(
   parameter int  ID_BITS = 64,
   localparam int OFF_W   = $clog2(ID_BITS / 8)
) (
   input  logic [ID_BITS-1:0] id_value,
   input  logic [OFF_W-1:0]   off,
   input  logic [1:0]         size,
   input  logic               hide,
   output logic [31:0]        data
);
   import bootlock_pkg::*;

   logic [ID_BITS-1:0] shifted;

   assign shifted = id_value >> {off, 3'b000};
   assign data    = hide ? 32'h0 : (shifted[31:0] & ones_for(size));

endmodule

// File: rtl/bootlock_rsp_stage.sv
module bootlock_rsp_stage #(
   parameter int W          = 8,
   parameter bit REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (REGISTERED) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_wire
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/bootrom_lock_ctrl.sv
module bootrom_lock_ctrl #(
   parameter logic [15:0] RST_VAL   = 16'h0101,
   parameter logic [15:0] WR_MASK   = 16'h0703,
   parameter logic [31:0] PRI_BASE  = 32'hFFFF_0000,
   parameter int          EXT_BYTES = 65536,
   parameter int          LEG_BYTES = 4096,
   parameter bit          REG_OUT   = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_wr,
   input  logic [1:0]                    cfg_wr_size,
   input  logic                          cfg_wr_hi,
   input  logic [15:0]                   cfg_wr_data,
   output logic [7:0]                    p_cfg_view,
   input  logic [1:0]                    s_cfg_size,
   input  logic                          s_cfg_hi,
   output logic [15:0]                   s_cfg_view,
   input  logic                          p_rd,
   input  logic [31:0]                   p_addr,
   input  logic [1:0]                    p_size,
   output logic                          p_rsp_vld,
   output logic [1:0]                    p_rsp_rom,
   output logic                          p_rsp_blk,
   output logic [$clog2(EXT_BYTES)-3:0]  p_rsp_word,
   output logic [31:0]                   p_rsp_ones,
   input  logic                          s_rd,
   input  logic [31:0]                   s_addr,
   input  logic [31:0]                   s_pc,
   input  logic [1:0]                    s_size,
   input  logic [15:0]                   s_bound,
   output logic                          s_rsp_vld,
   output logic [1:0]                    s_rsp_rom,
   output logic                          s_rsp_blk,
   output logic [$clog2(EXT_BYTES)-3:0]  s_rsp_word,
   output logic [31:0]                   s_rsp_ones,
   input  logic [63:0]                   id_value,
   input  logic                          id_rd,
   input  logic [2:0]                    id_off,
   input  logic [1:0]                    id_size,
   output logic                          id_rsp_vld,
   output logic [31:0]                   id_rsp_data
);
   import bootlock_pkg::*;

   localparam int WIW   = $clog2(EXT_BYTES) - 2;
   localparam int PRSPW = 1 + 2 + 1 + WIW + 32;
   localparam int IRSPW = 1 + 32;

   generate
      if ((LEG_BYTES > EXT_BYTES) || (LEG_BYTES < 4) || (EXT_BYTES > 65536)
          || ((EXT_BYTES & (EXT_BYTES - 1)) != 0) || ((LEG_BYTES & (LEG_BYTES - 1)) != 0)) begin : g_bad_cfg
         $error("bootrom_lock_ctrl: ROM sizes must be powers of two, legacy <= extended <= 64 KB");
      end
   endgenerate

   logic [15:0] lock_q;

   bootlock_reg #(.RST_VAL(RST_VAL), .WR_MASK(WR_MASK)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_size(cfg_wr_size), .wr_hi(cfg_wr_hi),
      .wr_data(cfg_wr_data), .rd_size(s_cfg_size), .rd_hi(s_cfg_hi),
      .lock(lock_q), .pri_view(p_cfg_view), .sec_view(s_cfg_view)
   );

   logic [1:0]     p_rom_d, s_rom_d;
   logic           p_blk_d, s_blk_d;
   logic [WIW-1:0] p_word_d, s_word_d;
   logic [31:0]    p_ones_d, s_ones_d, id_data_d;

   bootlock_pri_gate #(.BASE(PRI_BASE), .EXT_BYTES(EXT_BYTES), .LEG_BYTES(LEG_BYTES)) u_pri (
      .rd(p_rd), .addr(p_addr), .size(p_size),
      .lk_half(lock_q[LK_P_HALF]), .lk_legacy(lock_q[LK_P_LEGACY]),
      .rom(p_rom_d), .blk(p_blk_d), .word(p_word_d), .ones(p_ones_d)
   );

   bootlock_sec_gate #(.EXT_BYTES(EXT_BYTES)) u_sec (
      .rd(s_rd), .addr(s_addr), .pc(s_pc), .size(s_size), .bound(s_bound),
      .lk_half(lock_q[LK_S_HALF]), .lk_off(lock_q[LK_S_OFF]),
      .rom(s_rom_d), .blk(s_blk_d), .word(s_word_d), .ones(s_ones_d)
   );

   bootlock_id_gate #(.ID_BITS(64)) u_id (
      .id_value(id_value), .off(id_off), .size(id_size),
      .hide(lock_q[LK_ID_HIDE]), .data(id_data_d)
   );

   bootlock_rsp_stage #(.W(PRSPW), .REGISTERED(REG_OUT)) u_prsp (
      .clk(clk), .rst_n(rst_n),
      .d({p_rd, p_rom_d, p_blk_d, p_word_d, p_ones_d}),
      .q({p_rsp_vld, p_rsp_rom, p_rsp_blk, p_rsp_word, p_rsp_ones})
   );

   bootlock_rsp_stage #(.W(PRSPW), .REGISTERED(REG_OUT)) u_srsp (
      .clk(clk), .rst_n(rst_n),
      .d({s_rd, s_rom_d, s_blk_d, s_word_d, s_ones_d}),
      .q({s_rsp_vld, s_rsp_rom, s_rsp_blk, s_rsp_word, s_rsp_ones})
   );

   bootlock_rsp_stage #(.W(IRSPW), .REGISTERED(REG_OUT)) u_irsp (
      .clk(clk), .rst_n(rst_n),
      .d({id_rd, id_rd ? id_data_d : 32'h0}),
      .q({id_rsp_vld, id_rsp_data})
   );

endmodule

// File: rtl/bootrom_lock_chk.sv
module bootrom_lock_chk #(
   parameter logic [15:0] RST_VAL = 16'h0101,
   parameter bit          REG_OUT = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] lock,
   input logic        p_rd,
   input logic [31:0] p_addr,
   input logic [1:0]  p_rsp_rom,
   input logic        p_rsp_blk,
   input logic [31:0] p_rsp_ones,
   input logic        s_rd,
   input logic [31:0] s_addr,
   input logic [31:0] s_pc,
   input logic [1:0]  s_rsp_rom,
   input logic        s_rsp_blk,
   input logic        id_rd,
   input logic [31:0] id_rsp_data
);

   a_r1_reset_value: assert property (@(posedge clk) $rose(rst_n) |-> lock == RST_VAL);

   a_r2_never_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lock) & ~lock) == 16'h0);

   a_r12_quiet_ones: assert property (@(posedge clk) disable iff (!rst_n)
      !p_rsp_blk |-> p_rsp_ones == 32'h0);

   a_r12_blank_not_rom: assert property (@(posedge clk) disable iff (!rst_n)
      p_rsp_blk |-> p_rsp_rom == 2'd0);

   generate
      if (REG_OUT) begin : g_seq
         a_r7_legacy_hole: assert property (@(posedge clk) disable iff (!rst_n)
            p_rd && lock[1] && (p_addr >= 32'hFFFF_1000) |=> (p_rsp_rom == 2'd0) && !p_rsp_blk);

         a_r9_pc_outside: assert property (@(posedge clk) disable iff (!rst_n)
            s_rd && !lock[9] && (s_addr < 32'h0001_0000) && (s_pc >= 32'h0001_0000) |=> s_rsp_blk);

         a_r11_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
            s_rd && lock[9] |=> (s_rsp_rom == 2'd0) && !s_rsp_blk);

         a_r13_id_hidden: assert property (@(posedge clk) disable iff (!rst_n)
            id_rd && lock[10] |=> id_rsp_data == 32'h0);
      end
   endgenerate

endmodule

bind bootrom_lock_ctrl bootrom_lock_chk #(.RST_VAL(RST_VAL), .REG_OUT(REG_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .lock(lock_q),
   .p_rd(p_rd), .p_addr(p_addr), .p_rsp_rom(p_rsp_rom), .p_rsp_blk(p_rsp_blk), .p_rsp_ones(p_rsp_ones),
   .s_rd(s_rd), .s_addr(s_addr), .s_pc(s_pc), .s_rsp_rom(s_rsp_rom), .s_rsp_blk(s_rsp_blk),
   .id_rd(id_rd), .id_rsp_data(id_rsp_data)
);

// File: tb/bootrom_lock_ctrl_tb.sv
module bootrom_lock_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_wr_size = 2'd1;
   logic        cfg_wr_hi = 1'b0;
   logic [15:0] cfg_wr_data = 16'h0;
   logic [7:0]  p_cfg_view;
   logic [1:0]  s_cfg_size = 2'd1;
   logic        s_cfg_hi = 1'b0;
   logic [15:0] s_cfg_view;
   logic        p_rd = 1'b0;
   logic [31:0] p_addr = 32'h0;
   logic [1:0]  p_size = 2'd0;
   logic        p_rsp_vld, p_rsp_blk;
   logic [1:0]  p_rsp_rom;
   logic [13:0] p_rsp_word;
   logic [31:0] p_rsp_ones;
   logic        s_rd = 1'b0;
   logic [31:0] s_addr = 32'h0;
   logic [31:0] s_pc = 32'h0;
   logic [1:0]  s_size = 2'd0;
   logic [15:0] s_bound = 16'h0;
   logic        s_rsp_vld, s_rsp_blk;
   logic [1:0]  s_rsp_rom;
   logic [13:0] s_rsp_word;
   logic [31:0] s_rsp_ones;
   logic [63:0] id_value = 64'h8877_6655_4433_2211;
   logic        id_rd = 1'b0;
   logic [2:0]  id_off = 3'd0;
   logic [1:0]  id_size = 2'd0;
   logic        id_rsp_vld;
   logic [31:0] id_rsp_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [15:0] exp_lock;

   always #(CLK_PERIOD/2) clk = ~clk;

   bootrom_lock_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(cfg_wr), .cfg_wr_size(cfg_wr_size), .cfg_wr_hi(cfg_wr_hi), .cfg_wr_data(cfg_wr_data),
      .p_cfg_view(p_cfg_view), .s_cfg_size(s_cfg_size), .s_cfg_hi(s_cfg_hi), .s_cfg_view(s_cfg_view),
      .p_rd(p_rd), .p_addr(p_addr), .p_size(p_size),
      .p_rsp_vld(p_rsp_vld), .p_rsp_rom(p_rsp_rom), .p_rsp_blk(p_rsp_blk),
      .p_rsp_word(p_rsp_word), .p_rsp_ones(p_rsp_ones),
      .s_rd(s_rd), .s_addr(s_addr), .s_pc(s_pc), .s_size(s_size), .s_bound(s_bound),
      .s_rsp_vld(s_rsp_vld), .s_rsp_rom(s_rsp_rom), .s_rsp_blk(s_rsp_blk),
      .s_rsp_word(s_rsp_word), .s_rsp_ones(s_rsp_ones),
      .id_value(id_value), .id_rd(id_rd), .id_off(id_off), .id_size(id_size),
      .id_rsp_vld(id_rsp_vld), .id_rsp_data(id_rsp_data)
   );

   function automatic logic [31:0] sized_ones(input logic [1:0] sz);
      return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      exp_lock = 16'h0101;
   endtask

   task automatic lock_write(input logic [1:0] sz, input logic hi, input logic [15:0] data);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wr_size = sz; cfg_wr_hi = hi; cfg_wr_data = data;
      @(negedge clk);
      cfg_wr = 1'b0;
      if (sz == 2'd0) exp_lock |= hi ? {5'h0, data[2:0], 8'h0} : {14'h0, data[1:0]};
      else            exp_lock |= data & 16'h0703;
   endtask

   task automatic check_views(input string req);
      s_cfg_size = 2'd1; s_cfg_hi = 1'b0; #1;
      check({req, " R4 p_view"}, 64'(p_cfg_view), 64'(exp_lock[7:0]));
      check({req, " R4 s_view16"}, 64'(s_cfg_view), 64'(exp_lock));
      s_cfg_size = 2'd0; s_cfg_hi = 1'b1; #1;
      check({req, " R4 s_view_hi"}, 64'(s_cfg_view), 64'(exp_lock[15:8]));
      s_cfg_hi = 1'b0; #1;
      check({req, " R4 s_view_lo"}, 64'(s_cfg_view), 64'(exp_lock[7:0]));
      s_cfg_size = 2'd1;
   endtask

   task automatic pri_read(input logic [31:0] a, input logic [1:0] sz);
      logic [1:0] rom; logic blk; logic [13:0] word; string tag;
      rom = 2'd0; blk = 1'b0; word = 14'h0; tag = "R7";
      if (a >= 32'hFFFF_0000) begin
         if (!exp_lock[1]) begin
            if (exp_lock[0] && a >= 32'hFFFF_8000) begin blk = 1'b1; tag = "R6"; end
            else begin rom = 2'd2; word = a[15:2]; tag = "R5"; end
         end else if (a < 32'hFFFF_1000) begin
            rom = 2'd1; word = {4'h0, a[11:2]};
         end
      end
      @(negedge clk);
      p_rd = 1'b1; p_addr = a; p_size = sz;
      @(negedge clk);
      p_rd = 1'b0;
      check($sformatf("%s R12 pri a=%h sz=%0d", tag, a, sz),
            {14'h0, p_rsp_vld, p_rsp_rom, p_rsp_blk, p_rsp_word, p_rsp_ones},
            {14'h0, 1'b1, rom, blk, word, blk ? sized_ones(sz) : 32'h0});
   endtask

   task automatic sec_read(input logic [31:0] a, input logic [31:0] pc,
                           input logic [15:0] bnd, input logic [1:0] sz);
      logic [1:0] rom; logic blk; logic [13:0] word; string tag;
      rom = 2'd0; blk = 1'b0; word = 14'h0; tag = "R11";
      if (a < 32'h0001_0000 && !exp_lock[9]) begin
         if (exp_lock[8] && a >= 32'h8000)                 begin blk = 1'b1; tag = "R8"; end
         else if (pc >= 32'h0001_0000)                     begin blk = 1'b1; tag = "R9"; end
         else if (a < {16'h0, bnd} && pc >= {16'h0, bnd})  begin blk = 1'b1; tag = "R10"; end
         else begin rom = 2'd2; word = a[15:2]; tag = "R8"; end
      end
      @(negedge clk);
      s_rd = 1'b1; s_addr = a; s_pc = pc; s_bound = bnd; s_size = sz;
      @(negedge clk);
      s_rd = 1'b0;
      check($sformatf("%s R12 sec a=%h pc=%h b=%h sz=%0d", tag, a, pc, bnd, sz),
            {14'h0, s_rsp_vld, s_rsp_rom, s_rsp_blk, s_rsp_word, s_rsp_ones},
            {14'h0, 1'b1, rom, blk, word, blk ? sized_ones(sz) : 32'h0});
   endtask

   task automatic id_read(input logic [2:0] off, input logic [1:0] sz);
      logic [63:0] sh; logic [31:0] exp;
      sh  = id_value >> (8 * off);
      exp = exp_lock[10] ? 32'h0 : (sh[31:0] & sized_ones(sz));
      @(negedge clk);
      id_rd = 1'b1; id_off = off; id_size = sz;
      @(negedge clk);
      id_rd = 1'b0;
      check($sformatf("R13 id off=%0d sz=%0d", off, sz), {31'h0, id_rsp_vld, id_rsp_data}, {31'h0, 1'b1, exp});
   endtask

   localparam logic [31:0] P_ADDRS [10] = '{32'h0000_1000, 32'hFFFE_FFFC, 32'hFFFF_0000, 32'hFFFF_0FFC,
      32'hFFFF_1000, 32'hFFFF_4567, 32'hFFFF_7FFE, 32'hFFFF_8000, 32'hFFFF_9ABC, 32'hFFFF_FFFC};
   localparam logic [31:0] S_ADDRS [8] = '{32'h0, 32'h0FFC, 32'h1000, 32'h7FFC, 32'h8000,
      32'hFFFC, 32'h0001_0000, 32'h0200_0000};
   localparam logic [31:0] S_PCS [6] = '{32'h0, 32'h0FFF, 32'h1000, 32'h7FFC, 32'hFFFC, 32'h0001_0000};
   localparam logic [15:0] S_BNDS [3] = '{16'h0000, 16'h1000, 16'h8000};

   initial begin
      exp_lock = 16'h0101;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state of lock word and idle responses
      check("R1 reset lock", 64'(s_cfg_view), 64'h0101);
      check("R1 reset p_view", 64'(p_cfg_view), 64'h01);
      check("R1 idle rsp", {p_rsp_vld, s_rsp_vld, id_rsp_vld}, 64'h0);
      check_views("R1");

      // R3: byte writes with no settable bits leave the word alone
      lock_write(2'd0, 1'b0, 16'h00FC);
      check_views("R3 lo-none");
      lock_write(2'd0, 1'b1, 16'h00F8);
      check_views("R3 hi-none");
      // R2: 16-bit write outside mask
      lock_write(2'd1, 1'b0, 16'hF8FC);
      check("R2 mask", 64'(s_cfg_view), 64'h0101);
      lock_write(2'd0, 1'b0, 16'h0002);
      check("R3 lo-set", 64'(s_cfg_view), 64'h0103);
      lock_write(2'd1, 1'b0, 16'h0000);
      check("R2 no-clear", 64'(s_cfg_view), 64'h0103);
      lock_write(2'd0, 1'b1, 16'h0004);
      check("R3 hi-set", 64'(s_cfg_view), 64'h0503);
      lock_write(2'd2, 1'b0, 16'hFFFF);
      check("R2 word", 64'(s_cfg_view), 64'h0703);
      check_views("R2");

      for (int c = 0; c < 8; c++) begin
         do_reset();
         lock_write((c % 2 == 1) ? 2'd2 : 2'd1, 1'b0,
                    {5'h0, c[2], c[1], 7'h0, c[0], 1'b0});
         check_views($sformatf("R2 cfg%0d", c));
         for (int a = 0; a < 10; a++)
            for (int sz = 0; sz < 3; sz++) pri_read(P_ADDRS[a], 2'(sz));
         for (int a = 0; a < 8; a++)
            for (int p = 0; p < 6; p++)
               for (int b = 0; b < 3; b++)
                  for (int sz = 0; sz < 3; sz++) sec_read(S_ADDRS[a], S_PCS[p], S_BNDS[b], 2'(sz));
         for (int o = 0; o < 8; o++)
            for (int sz = 0; sz < 3; sz++) id_read(3'(o), 2'(sz));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog act=running exp=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule